// File: doc/BRIEF.md
# Integer Execute Stage with Paired-Register Multiply

This block is the execute step of a five-stage 32-bit integer pipeline. On each cycle that `valid_i` is high it takes one instruction word, the two source register values already read from the register file, and the incremented program counter. It decodes the instruction and computes the arithmetic, logic, shift, compare, address or branch result. One clock later it presents the result, the memory request, the branch decision and the write-back controls.

Sixteen operations are accepted: register add, subtract, and, or, the two immediate-count shifts, a multiply, immediate add, and, or, upper-load, signed and unsigned set-less-than, word load, word store and branch-on-equal. The multiply produces a full 64-bit product. Its low half is written back through the normal destination port to `rd`. Its high half goes through a second write-back port to register `rd+1`. A write aimed at register zero is never enabled.

Any other encoding still produces a valid output cycle, but none of its enables is set. Pipeline registers, hazard handling, memories and register storage are outside the block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: `valid_o` equals `valid_i` delayed by one clock, and every enable output is low when `valid_o` is low. `result_o` holds its value across cycles in which `valid_i` was low.
- R3: The field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0] and immediate [15:0]. With opcode 0, funct 0x20 adds, 0x22 subtracts, 0x24 ands and 0x25 ors the rs and rt values. Arithmetic wraps modulo 2^32, and the result is written to rd.
- R4: With opcode 0, funct 0x00 shifts the rt value left by shamt and funct 0x02 shifts it right by shamt, filling with zeros. The result is written to rd.
- R5: With opcode 0 and funct 0x18, the signed rs and rt values are multiplied. The low 32 product bits go to `result_o` with destination rd. The high 32 bits go to `hi_result_o` with pair destination rd+1.
- R6: No enabled write-back ever targets register 0. When the destination field is 0, `wr_en_o` stays low while the other outputs still follow the instruction.
- R7: A multiply with rd = 31 enables the low-word write and leaves `pair_wr_en_o` low.
- R8: Opcode 0x08 adds the sign-extended immediate to rs. Opcode 0x0C ands rs with the zero-extended immediate, and 0x0D ors it. Opcode 0x0F places the immediate in bits [31:16] with zeros below. All four write to rt.
- R9: Opcode 0x0A writes 1 to rt if rs is less than the sign-extended immediate as signed numbers, and 0 otherwise. Opcode 0x0B makes the same comparison as unsigned numbers.
- R10: Opcodes 0x23 (load) and 0x2B (store) drive `mem_addr_o` = rs + sign-extended immediate. A load raises `mem_rd_o` and a write-back to rt. A store raises `mem_wr_o`, drives the rt value on `store_data_o`, and enables no write-back.
- R11: Opcode 0x04 raises `br_taken_o` exactly when the rs and rt values are equal. `br_target_o` is the PC+4 input plus the sign-extended immediate shifted left by two.
- R12: Any other opcode, or opcode 0 with any other funct, leaves all enables and `br_taken_o` low while `valid_o` still rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands present this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | DATA_W | Value of register rs |
| rt_val_i | input | DATA_W | Value of register rt |
| pc_plus4_i | input | DATA_W | Address of the following instruction |
| valid_o | output | 1 | Registered result present |
| result_o | output | DATA_W | ALU result, or the low product word |
| hi_result_o | output | DATA_W | High product word |
| wr_en_o | output | 1 | Primary write-back enable |
| wr_idx_o | output | REG_AW | Primary write-back register |
| pair_wr_en_o | output | 1 | Second write-back enable (multiply) |
| pair_wr_idx_o | output | REG_AW | Second write-back register |
| mem_rd_o | output | 1 | Data memory read request |
| mem_wr_o | output | 1 | Data memory write request |
| mem_addr_o | output | DATA_W | Data memory byte address |
| store_data_o | output | DATA_W | Data to store |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | DATA_W | Branch target address |

## Verification
The bench builds the block at its defaults: a 32-bit datapath, 5-bit register indices and a signed multiplier. At that size the index arithmetic and the data values can both be pushed to their edges. A multiply into rd = 31 reaches the point where rd+1 would wrap to register 0. Operands such as 0x80000000 and 0xFFFFFFFF drive the 64-bit product's high word through its sign cases. The same operands make the signed and unsigned compares disagree and send the right shift across the sign bit.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int INSTR_W = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LUI   = 6'h0F;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_MUL = 6'h18;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLL, OP_SRL, OP_MUL,
    OP_ADDI, OP_ANDI, OP_ORI, OP_LUI, OP_SLTI, OP_SLTIU, OP_LW, OP_SW, OP_BEQ
  } op_e;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic [AW-1:0]      dst_o,
  output logic               wr_o,
  output logic               pair_o,
  output logic               ld_o,
  output logic               st_o,
  output logic [DW-1:0]      imm_o,
  output logic [4:0]         shamt_o
);
  logic [5:0]    opc, funct;
  logic [AW-1:0] rt, rd;
  logic [15:0]   imm16;
  logic          is_rtype, writes;
  logic          unused_rs;

  assign opc       = instr_i[31:26];
  assign funct     = instr_i[5:0];
  assign rt        = instr_i[16 +: AW];
  assign rd        = instr_i[11 +: AW];
  assign imm16     = instr_i[15:0];
  assign shamt_o   = instr_i[10:6];
  assign unused_rs = ^instr_i[25:21];

  always_comb begin
    op_o = OP_NONE;
    unique case (opc)
      OPC_RTYPE: begin
        unique case (funct)
          FN_ADD:  op_o = OP_ADD;
          FN_SUB:  op_o = OP_SUB;
          FN_AND:  op_o = OP_AND;
          FN_OR:   op_o = OP_OR;
          FN_SLL:  op_o = OP_SLL;
          FN_SRL:  op_o = OP_SRL;
          FN_MUL:  op_o = OP_MUL;
          default: op_o = OP_NONE;
        endcase
      end
      OPC_ADDI:  op_o = OP_ADDI;
      OPC_ANDI:  op_o = OP_ANDI;
      OPC_ORI:   op_o = OP_ORI;
      OPC_LUI:   op_o = OP_LUI;
      OPC_SLTI:  op_o = OP_SLTI;
      OPC_SLTIU: op_o = OP_SLTIU;
      OPC_LW:    op_o = OP_LW;
      OPC_SW:    op_o = OP_SW;
      OPC_BEQ:   op_o = OP_BEQ;
      default:   op_o = OP_NONE;
    endcase
  end

  assign is_rtype = op_o inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLL, OP_SRL, OP_MUL};
  assign writes   = !(op_o inside {OP_NONE, OP_SW, OP_BEQ});
  assign dst_o    = is_rtype ? rd : rt;
  assign wr_o     = writes && (dst_o != '0);
  // rd+1 does not exist for the last register
  assign pair_o   = (op_o == OP_MUL) && (rd != '1);
  assign ld_o     = (op_o == OP_LW);
  assign st_o     = (op_o == OP_SW);

  always_comb begin
    unique case (op_o)
      OP_ANDI, OP_ORI: imm_o = {{(DW-16){1'b0}}, imm16};
      OP_LUI:          imm_o = {imm16, {(DW-16){1'b0}}};
      default:         imm_o = {{(DW-16){imm16[15]}}, imm16};
    endcase
  end
endmodule

// File: rtl/exec_mul.sv
module exec_mul #(
  parameter int DW         = 32,
  parameter bit SIGNED_MUL = 1'b1
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] prod_o
);
  logic [2*DW-1:0] a_ext, b_ext;

  generate
    if (SIGNED_MUL) begin : g_signed
      assign a_ext = {{DW{a_i[DW-1]}}, a_i};
      assign b_ext = {{DW{b_i[DW-1]}}, b_i};
    end else begin : g_unsigned
      assign a_ext = {{DW{1'b0}}, a_i};
      assign b_ext = {{DW{1'b0}}, b_i};
    end
  endgenerate

  // low 2*DW bits of the extended product are exact in both cases
  assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] imm_i,
  input  logic [4:0]    shamt_i,
  input  logic [DW-1:0] pc4_i,
  output logic [DW-1:0] result_o,
  output logic [DW-1:0] addr_o,
  output logic          br_taken_o,
  output logic [DW-1:0] br_target_o
);
  logic lt_s, lt_u;
  logic unused_imm_top;

  assign lt_s           = $signed(a_i) < $signed(imm_i);
  assign lt_u           = a_i < imm_i;
  assign addr_o         = a_i + imm_i;
  assign br_taken_o     = (op_i == OP_BEQ) && (a_i == b_i);
  assign br_target_o    = pc4_i + {imm_i[DW-3:0], 2'b00};
  assign unused_imm_top = ^imm_i[DW-1:DW-2];

  always_comb begin
    unique case (op_i)
      OP_ADD:   result_o = a_i + b_i;
      OP_SUB:   result_o = a_i - b_i;
      OP_AND:   result_o = a_i & b_i;
      OP_OR:    result_o = a_i | b_i;
      OP_SLL:   result_o = b_i << shamt_i;
      OP_SRL:   result_o = b_i >> shamt_i;
      OP_ADDI:  result_o = a_i + imm_i;
      OP_ANDI:  result_o = a_i & imm_i;
      OP_ORI:   result_o = a_i | imm_i;
      OP_LUI:   result_o = imm_i;
      OP_SLTI:  result_o = {{(DW-1){1'b0}}, lt_s};
      OP_SLTIU: result_o = {{(DW-1){1'b0}}, lt_u};
      OP_LW, OP_SW: result_o = addr_o;
      default:  result_o = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_AW     = 5,
  parameter bit SIGNED_MUL = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_val_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  input  logic [DATA_W-1:0]  pc_plus4_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic [DATA_W-1:0]  hi_result_o,
  output logic               wr_en_o,
  output logic [REG_AW-1:0]  wr_idx_o,
  output logic               pair_wr_en_o,
  output logic [REG_AW-1:0]  pair_wr_idx_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [DATA_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  store_data_o,
  output logic               br_taken_o,
  output logic [DATA_W-1:0]  br_target_o
);
  localparam int PROD_W = 2 * DATA_W;

  op_e                op;
  logic [REG_AW-1:0]  dst;
  logic               dec_wr, dec_pair, dec_ld, dec_st;
  logic [DATA_W-1:0]  imm_ext, alu_res, alu_addr, br_tgt;
  logic [4:0]         shamt;
  logic               br_hit;
  logic [PROD_W-1:0]  prod;
  logic [DATA_W-1:0]  res_next;

  exec_decode #(.DW(DATA_W), .AW(REG_AW)) u_dec (
    .instr_i (instr_i),
    .op_o    (op),
    .dst_o   (dst),
    .wr_o    (dec_wr),
    .pair_o  (dec_pair),
    .ld_o    (dec_ld),
    .st_o    (dec_st),
    .imm_o   (imm_ext),
    .shamt_o (shamt)
  );

  exec_alu #(.DW(DATA_W)) u_alu (
    .op_i        (op),
    .a_i         (rs_val_i),
    .b_i         (rt_val_i),
    .imm_i       (imm_ext),
    .shamt_i     (shamt),
    .pc4_i       (pc_plus4_i),
    .result_o    (alu_res),
    .addr_o      (alu_addr),
    .br_taken_o  (br_hit),
    .br_target_o (br_tgt)
  );

  exec_mul #(.DW(DATA_W), .SIGNED_MUL(SIGNED_MUL)) u_mul (
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .prod_o (prod)
  );

  assign res_next = (op == OP_MUL) ? prod[DATA_W-1:0] : alu_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      wr_en_o      <= 1'b0;
      pair_wr_en_o <= 1'b0;
      mem_rd_o     <= 1'b0;
      mem_wr_o     <= 1'b0;
      br_taken_o   <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      wr_en_o      <= valid_i & dec_wr;
      pair_wr_en_o <= valid_i & dec_pair;
      mem_rd_o     <= valid_i & dec_ld;
      mem_wr_o     <= valid_i & dec_st;
      br_taken_o   <= valid_i & br_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o      <= '0;
      hi_result_o   <= '0;
      wr_idx_o      <= '0;
      pair_wr_idx_o <= '0;
      mem_addr_o    <= '0;
      store_data_o  <= '0;
      br_target_o   <= '0;
    end else if (valid_i) begin
      result_o      <= res_next;
      hi_result_o   <= prod[PROD_W-1:DATA_W];
      wr_idx_o      <= dst;
      pair_wr_idx_o <= dst + 1'b1;
      mem_addr_o    <= alu_addr;
      store_data_o  <= rt_val_i;
      br_target_o   <= br_tgt;
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          valid_o,
  input logic [DW-1:0] result_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_idx_o,
  input logic          pair_wr_en_o,
  input logic [AW-1:0] pair_wr_idx_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          br_taken_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(wr_en_o || pair_wr_en_o || mem_rd_o || mem_wr_o || br_taken_o)); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R2
  AST_NO_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o != '0)); // R6
  AST_PAIR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_wr_en_o |-> (pair_wr_idx_o != '0)); // R7
  AST_PAIR_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_wr_en_o |-> (pair_wr_idx_o == AW'(wr_idx_o + 1'b1))); // R5
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, br_taken_o})); // R10
  AST_STORE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !(wr_en_o || pair_wr_en_o)); // R10
endmodule

bind int_exec_unit int_exec_unit_chk #(.DW(DATA_W), .AW(REG_AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .valid_o       (valid_o),
  .result_o      (result_o),
  .wr_en_o       (wr_en_o),
  .wr_idx_o      (wr_idx_o),
  .pair_wr_en_o  (pair_wr_en_o),
  .pair_wr_idx_o (pair_wr_idx_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .br_taken_o    (br_taken_o)
);

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0, rs_val_i = '0, rt_val_i = '0, pc_plus4_i = '0;
  logic        valid_o, wr_en_o, pair_wr_en_o, mem_rd_o, mem_wr_o, br_taken_o;
  logic [31:0] result_o, hi_result_o, mem_addr_o, store_data_o, br_target_o;
  logic [4:0]  wr_idx_o, pair_wr_idx_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_plus4_i(pc_plus4_i),
    .valid_o(valid_o), .result_o(result_o), .hi_result_o(hi_result_o),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .pair_wr_en_o(pair_wr_en_o),
    .pair_wr_idx_o(pair_wr_idx_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .store_data_o(store_data_o),
    .br_taken_o(br_taken_o), .br_target_o(br_target_o)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  widx;
    logic        pr;
    logic [4:0]  pidx;
    logic [31:0] res;
    logic [31:0] hi;
    logic        ld, st, bt;
    logic [31:0] addr, sdata, btgt;
    logic        c_res, c_hi, c_mem, c_br;
  } exp_t;

  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] pc4,
                                 output string req);
    exp_t e;
    logic [5:0]  opc = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    logic [4:0]  rt  = ins[20:16];
    logic [4:0]  rd  = ins[15:11];
    logic [4:0]  sh  = ins[10:6];
    logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx  = {16'h0, ins[15:0]};
    longint sa, sb, p;
    e = '0;
    req = "R12";
    if (opc == 6'h00) begin
      e.widx = rd; e.c_res = 1'b1; e.wr = 1'b1;
      case (fn)
        6'h20: begin e.res = a + b; req = "R3"; end
        6'h22: begin e.res = a - b; req = "R3"; end
        6'h24: begin e.res = a & b; req = "R3"; end
        6'h25: begin e.res = a | b; req = "R3"; end
        6'h00: begin e.res = b << sh; req = "R4"; end
        6'h02: begin e.res = b >> sh; req = "R4"; end
        6'h18: begin
          sa = $signed(a); sb = $signed(b); p = sa * sb;
          e.res = p[31:0]; e.hi = p[63:32]; e.c_hi = 1'b1;
          e.pr = (rd != 5'd31); e.pidx = rd + 5'd1;
          req = (rd == 5'd31) ? "R7" : "R5";
        end
        default: begin e.wr = 1'b0; e.c_res = 1'b0; req = "R12"; end
      endcase
    end else begin
      e.widx = rt; e.wr = 1'b1; e.c_res = 1'b1;
      case (opc)
        6'h08: begin e.res = a + sx; req = "R8"; end
        6'h0C: begin e.res = a & zx; req = "R8"; end
        6'h0D: begin e.res = a | zx; req = "R8"; end
        6'h0F: begin e.res = {ins[15:0], 16'h0}; req = "R8"; end
        6'h0A: begin e.res = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; req = "R9"; end
        6'h0B: begin e.res = (a < sx) ? 32'd1 : 32'd0; req = "R9"; end
        6'h23: begin e.c_res = 1'b0; e.ld = 1'b1; e.addr = a + sx; e.c_mem = 1'b1; req = "R10"; end
        6'h2B: begin e.c_res = 1'b0; e.wr = 1'b0; e.st = 1'b1; e.addr = a + sx;
                     e.sdata = b; e.c_mem = 1'b1; req = "R10"; end
        6'h04: begin e.c_res = 1'b0; e.wr = 1'b0; e.bt = (a == b);
                     e.btgt = pc4 + (sx << 2); e.c_br = 1'b1; req = "R11"; end
        default: begin e.wr = 1'b0; e.c_res = 1'b0; req = "R12"; end
      endcase
    end
    if (e.wr && e.widx == 5'd0) begin
      e.wr = 1'b0;
      if (req != "R7") req = "R6";
    end
    return e;
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] pc4);
    exp_t  e;
    string req;
    bit    ok;
    e = model(ins, a, b, pc4, req);
    instr_i = ins; rs_val_i = a; rt_val_i = b; pc_plus4_i = pc4; valid_i = 1'b1;
    @(negedge clk);
    ok = (valid_o == 1'b1) && (wr_en_o == e.wr) && (pair_wr_en_o == e.pr) &&
         (mem_rd_o == e.ld) && (mem_wr_o == e.st) && (br_taken_o == e.bt);
    if (e.wr && wr_idx_o != e.widx) ok = 1'b0;
    if (e.pr && pair_wr_idx_o != e.pidx) ok = 1'b0;
    if (e.c_res && result_o != e.res) ok = 1'b0;
    if (e.c_hi && hi_result_o != e.hi) ok = 1'b0;
    if (e.c_mem && mem_addr_o != e.addr) ok = 1'b0;
    if (e.st && store_data_o != e.sdata) ok = 1'b0;
    if (e.c_br && br_target_o != e.btgt) ok = 1'b0;
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s instr=%h a=%h b=%h: got v=%b wr=%b/%0d pr=%b/%0d res=%h hi=%h ld=%b st=%b addr=%h sd=%h bt=%b tgt=%h; exp wr=%b/%0d pr=%b/%0d res=%h hi=%h ld=%b st=%b addr=%h sd=%h bt=%b tgt=%h",
               req, ins, a, b, valid_o, wr_en_o, wr_idx_o, pair_wr_en_o, pair_wr_idx_o,
               result_o, hi_result_o, mem_rd_o, mem_wr_o, mem_addr_o, store_data_o,
               br_taken_o, br_target_o, e.wr, e.widx, e.pr, e.pidx, e.res, e.hi,
               e.ld, e.st, e.addr, e.sdata, e.bt, e.btgt);
    end
  endtask

  function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] opc, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  function automatic logic [31:0] pick_word();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  function automatic logic [31:0] pick_instr();
    logic [5:0] fns [7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h00, 6'h02, 6'h18};
    logic [5:0] ops [9] = '{6'h08, 6'h0C, 6'h0D, 6'h0F, 6'h0A, 6'h0B, 6'h23, 6'h2B, 6'h04};
    int k = $urandom_range(0, 16);
    logic [31:0] r = $urandom();
    if (k < 7) return {6'h00, r[25:6], fns[k]};
    if (k < 16) return {ops[k-7], r[25:0]};
    return {6'h3F, r[25:0]};
  endfunction

  task automatic check_hold();
    logic [31:0] prev = result_o;
    bit ok;
    valid_i = 1'b0;
    instr_i = rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h20);
    rs_val_i = 32'h1234_5678;
    @(negedge clk);
    ok = !valid_o && !wr_en_o && !pair_wr_en_o && !mem_rd_o && !mem_wr_o &&
         !br_taken_o && (result_o == prev);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R2 idle: got v=%b wr=%b pr=%b ld=%b st=%b bt=%b res=%h; exp all 0 res=%h",
               valid_o, wr_en_o, pair_wr_en_o, mem_rd_o, mem_wr_o, br_taken_o, result_o, prev);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    n_vec++;
    if (valid_o || wr_en_o || pair_wr_en_o || mem_rd_o || mem_wr_o || br_taken_o ||
        result_o != 0 || hi_result_o != 0 || mem_addr_o != 0 || store_data_o != 0 ||
        br_target_o != 0 || wr_idx_o != 0 || pair_wr_idx_o != 0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b res=%h hi=%h; exp all zero", valid_o, result_o, hi_result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // directed corners
    apply(rtype(5'd8, 5'd9, 5'd5, 5'd0, 6'h18), 32'hFFFF_FFFD, 32'd7, 32'h100);       // R5
    apply(rtype(5'd8, 5'd9, 5'd10, 5'd0, 6'h18), 32'h8000_0000, 32'h8000_0000, 32'h0); // R5
    apply(rtype(5'd8, 5'd9, 5'd0, 5'd0, 6'h18), 32'hFFFF_FFFF, 32'd2, 32'h0);          // R6 mul rd=0
    apply(rtype(5'd8, 5'd9, 5'd31, 5'd0, 6'h18), 32'h0001_0000, 32'hFFFF_0000, 32'h0); // R7
    apply(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'hFFFF_FFFF, 32'd1, 32'h0);          // R3 wrap
    apply(rtype(5'd0, 5'd2, 5'd4, 5'd31, 6'h02), 32'h0, 32'h8000_0000, 32'h0);         // R4 zero fill
    apply(rtype(5'd0, 5'd2, 5'd4, 5'd4, 6'h00), 32'h0, 32'hF000_000F, 32'h0);          // R4
    apply(itype(6'h0B, 5'd1, 5'd2, 16'hFFFF), 32'h7FFF_FFFF, 32'h0, 32'h0);            // R9 unsigned
    apply(itype(6'h0A, 5'd1, 5'd2, 16'hFFFF), 32'h8000_0000, 32'h0, 32'h0);            // R9 signed
    apply(itype(6'h0C, 5'd1, 5'd2, 16'h8F0F), 32'hFFFF_FFFF, 32'h0, 32'h0);            // R8 zext
    apply(itype(6'h0F, 5'd0, 5'd7, 16'hBEEF), 32'h1111_1111, 32'h0, 32'h0);            // R8 lui
    apply(itype(6'h08, 5'd1, 5'd0, 16'h0005), 32'd10, 32'h0, 32'h0);                   // R6 addi to r0
    apply(itype(6'h23, 5'd1, 5'd2, 16'hFFFC), 32'h0000_0100, 32'h0, 32'h0);            // R10 load
    apply(itype(6'h2B, 5'd1, 5'd2, 16'h0008), 32'h0000_0200, 32'hCAFE_F00D, 32'h0);    // R10 store
    apply(itype(6'h04, 5'd1, 5'd2, 16'hFFFE), 32'h55, 32'h55, 32'h0000_1000);          // R11 taken
    apply(itype(6'h04, 5'd1, 5'd2, 16'h0010), 32'h55, 32'h56, 32'h0000_1000);          // R11 not taken
    apply(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h1, 32'h2, 32'h0);                  // R12 funct
    apply(itype(6'h3F, 5'd1, 5'd2, 16'h1), 32'h1, 32'h2, 32'h0);                       // R12 opcode
    check_hold();                                                                     // R2

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ins = pick_instr();
      logic [31:0] a = pick_word();
      logic [31:0] b = ($urandom_range(0, 3) == 0) ? a : pick_word();
      apply(ins, a, b, {$urandom(), 2'b00} & 32'h0000_FFFC);
      if ($urandom_range(0, 15) == 0) check_hold();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule